// File: doc/BRIEF.md
# Ethernet Transmit Inter-Frame Gap Controller

This block sits between the client side of a tri-mode Ethernet transmitter and its transmit engine. It holds the client off between back-to-back frames until the required idle gap has passed. The gap is measured in byte times. The counter advances only on a byte-time enable, so the same logic serves 10, 100 and 1000 Mb/s line rates.

The gap value is chosen when a frame starts and stored until that frame ends. In half duplex the value is a fixed minimum, and that minimum depends on the PHY interface: 18 byte times for MII and 26 for RGMII. In full duplex the default is 12 byte times. When the adjust-enable bit is set in full duplex, the client's gap-length input sets the gap instead, and any value below 12 is raised to 12.

When `frame_end` pulses, the counter loads the stored gap on the next clock edge. The ready output then stays low until the counter has counted down to zero.

Top module: `ifg_gap_ctrl`

## Requirements
- R1: After reset no gap is pending: `tx_ready` is 1 on the first clock after reset is released.
- R2: In full duplex (`full_duplex`=1) with `gap_adj_en`=0, `tx_ready` stays low for exactly 12 enabled byte times after a frame ends.
- R3: In half duplex (`full_duplex`=0) with `phy_rgmii`=0 (MII), the gap is 18 byte times.
- R4: In half duplex with `phy_rgmii`=1 (RGMII), the gap is 26 byte times.
- R5: In full duplex with `gap_adj_en`=1, the gap equals the `gap_req` value sampled on the clock edge where `sof_req`=1.
- R6: In full duplex with `gap_adj_en`=1, a sampled `gap_req` below 12 (including 0) gives a gap of 12.
- R7: In half duplex, `gap_adj_en` and `gap_req` have no effect; the fixed minimum of R3/R4 applies.
- R8: Changes on `gap_req`, `gap_adj_en`, `full_duplex` or `phy_rgmii` after `sof_req` do not change the gap that follows that frame.
- R9: The gap counter decrements only on clocks where `byte_en`=1; while `byte_en`=0, `tx_ready` holds its value.
- R10: `tx_ready` falls on the clock edge where `frame_end`=1 is sampled. The count starts on the following cycle, and `tx_ready` rises on the edge that takes the count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_en | input | 1 | Byte-time enable; one pulse per byte time on the line |
| sof_req | input | 1 | Start-of-frame pulse; samples the gap selection |
| frame_end | input | 1 | Pulse on the last byte of a frame |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| phy_rgmii | input | 1 | 1 = RGMII PHY interface, 0 = MII |
| gap_adj_en | input | 1 | Enables a client-set gap (full duplex only) |
| gap_req | input | GAP_W | Requested gap in byte times |
| tx_ready | output | 1 | 1 = client may start the next frame |

## Verification
The hardest case to reach is a gap value that arrives on `gap_req` and is then withdrawn while the frame is still in progress. Only the value present at frame start may set the gap. To create this case, every table entry first pulses `sof_req`, then drives `gap_req` to 3 and flips `gap_adj_en` before pulsing `frame_end`. A second case holds `byte_en` low for a long stretch after the frame ends and confirms that `tx_ready` neither rises nor loses count during that stretch.

// File: rtl/ifg_pkg.sv
package ifg_pkg;
  typedef enum logic {
    PHY_MII   = 1'b0,
    PHY_RGMII = 1'b1
  } phy_if_e;

  typedef enum logic [1:0] {
    SRC_FD_FIXED  = 2'd0,
    SRC_FD_CLIENT = 2'd1,
    SRC_HD_MII    = 2'd2,
    SRC_HD_RGMII  = 2'd3
  } gap_src_e;
endpackage

// File: rtl/ifg_gap_select.sv
module ifg_gap_select
  import ifg_pkg::*;
#(
  parameter int GAP_W        = 8,
  parameter int FD_MIN       = 12,
  parameter int HD_MII_MIN   = 18,
  parameter int HD_RGMII_MIN = 26
) (
  input  logic             full_duplex,
  input  logic             phy_rgmii,
  input  logic             adj_en,
  input  logic [GAP_W-1:0] gap_req,
  output logic [GAP_W-1:0] gap_sel
);
  localparam logic [GAP_W-1:0] FD_V  = GAP_W'(FD_MIN);
  localparam logic [GAP_W-1:0] MII_V = GAP_W'(HD_MII_MIN);
  localparam logic [GAP_W-1:0] RGM_V = GAP_W'(HD_RGMII_MIN);

  gap_src_e src;
  phy_if_e  phy;

  always_comb begin
    phy = phy_if_e'(phy_rgmii);
    if (full_duplex) src = adj_en ? SRC_FD_CLIENT : SRC_FD_FIXED;
    else             src = (phy == PHY_RGMII) ? SRC_HD_RGMII : SRC_HD_MII;
  end

  always_comb begin
    unique case (src)
      SRC_FD_CLIENT: gap_sel = (gap_req < FD_V) ? FD_V : gap_req;
      SRC_HD_MII:    gap_sel = MII_V;
      SRC_HD_RGMII:  gap_sel = RGM_V;
      default:       gap_sel = FD_V;
    endcase
  end

  // R6: the selected gap never drops below the full-duplex minimum
  always_comb begin
    p_clamp_r6: assert (gap_sel >= FD_V);
  end
endmodule

// File: rtl/ifg_gap_counter.sv
module ifg_gap_counter #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  input  logic             tick,
  output logic [GAP_W-1:0] cnt,
  output logic             ready
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ready <= 1'b1;
    end else if (load) begin
      cnt   <= load_val;
      ready <= (load_val == '0);
    end else if (tick && cnt != '0) begin
      cnt   <= cnt - 1'b1;
      ready <= (cnt == GAP_W'(1));
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (ready && cnt == '0));

  p_dec_r9: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> ($stable(cnt) && $stable(ready)));

  p_load_r10: assert property (@(posedge clk) disable iff (rst)
    (load && load_val != '0) |=> !ready);
endmodule

// File: rtl/ifg_gap_ctrl.sv
module ifg_gap_ctrl #(
  parameter int GAP_W        = 8,
  parameter int FD_MIN       = 12,
  parameter int HD_MII_MIN   = 18,
  parameter int HD_RGMII_MIN = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_en,
  input  logic             sof_req,
  input  logic             frame_end,
  input  logic             full_duplex,
  input  logic             phy_rgmii,
  input  logic             gap_adj_en,
  input  logic [GAP_W-1:0] gap_req,
  output logic             tx_ready
);
  logic [GAP_W-1:0] gap_sel;
  logic [GAP_W-1:0] gap_lat;
  logic [GAP_W-1:0] cnt;

  ifg_gap_select #(
    .GAP_W(GAP_W), .FD_MIN(FD_MIN),
    .HD_MII_MIN(HD_MII_MIN), .HD_RGMII_MIN(HD_RGMII_MIN)
  ) u_sel (
    .full_duplex(full_duplex),
    .phy_rgmii  (phy_rgmii),
    .adj_en     (gap_adj_en),
    .gap_req    (gap_req),
    .gap_sel    (gap_sel)
  );

  // gap value captured at frame start (R8)
  always_ff @(posedge clk) begin
    if (rst)          gap_lat <= GAP_W'(FD_MIN);
    else if (sof_req) gap_lat <= gap_sel;
  end

  ifg_gap_counter #(.GAP_W(GAP_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (frame_end),
    .load_val(gap_lat),
    .tick    (byte_en),
    .cnt     (cnt),
    .ready   (tx_ready)
  );

  p_latch_r8: assert property (@(posedge clk) disable iff (rst)
    !sof_req |=> $stable(gap_lat));

  p_hd_min_r7: assert property (@(posedge clk) disable iff (rst)
    (sof_req && !full_duplex) |=> (gap_lat >= GAP_W'(HD_MII_MIN)));

  p_end_r10: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (!tx_ready && cnt == $past(gap_lat)));
endmodule

// File: tb/ifg_gap_ctrl_bench.sv
module ifg_gap_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int GAP_W = 8;

  logic clk = 1'b0;
  logic rst, byte_en, sof_req, frame_end, full_duplex, phy_rgmii, gap_adj_en;
  logic [GAP_W-1:0] gap_req;
  logic tx_ready;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifg_gap_ctrl #(.GAP_W(GAP_W)) u_ifg_gap_ctrl (
    .clk(clk), .rst(rst), .byte_en(byte_en), .sof_req(sof_req),
    .frame_end(frame_end), .full_duplex(full_duplex), .phy_rgmii(phy_rgmii),
    .gap_adj_en(gap_adj_en), .gap_req(gap_req), .tx_ready(tx_ready)
  );

  // {full_duplex, phy_rgmii, adj_en, gap_req[7:0], expected_gap[7:0]}
  localparam int NV = 9;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 8'd40, 8'd12},  // R2
    {1'b1, 1'b1, 1'b0, 8'd3,  8'd12},  // R2 rgmii
    {1'b0, 1'b0, 1'b0, 8'd0,  8'd18},  // R3
    {1'b0, 1'b1, 1'b0, 8'd0,  8'd26},  // R4
    {1'b1, 1'b0, 1'b1, 8'd40, 8'd40},  // R5
    {1'b1, 1'b1, 1'b1, 8'd13, 8'd13},  // R5
    {1'b1, 1'b0, 1'b1, 8'd5,  8'd12},  // R6
    {1'b1, 1'b0, 1'b1, 8'd0,  8'd12},  // R6 zero
    {1'b0, 1'b1, 1'b1, 8'd60, 8'd26}   // R7
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pulse frame_end, then count cycles with tx_ready low
  task automatic run_gap(output int n);
    @(negedge clk) frame_end = 1'b1;
    @(negedge clk) frame_end = 1'b0;
    n = 0;
    while (!tx_ready && n < 300) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    rst = 1'b1; byte_en = 1'b1; sof_req = 1'b0; frame_end = 1'b0;
    full_duplex = 1'b1; phy_rgmii = 1'b0; gap_adj_en = 1'b0; gap_req = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(tx_ready == 1'b1, "R1 ready after reset", tx_ready, 1);

    for (int i = 0; i < NV; i++) begin
      full_duplex = VEC[i][18];
      phy_rgmii   = VEC[i][17];
      gap_adj_en  = VEC[i][16];
      gap_req     = VEC[i][15:8];
      @(negedge clk) sof_req = 1'b1;
      @(negedge clk) sof_req = 1'b0;
      // R8: disturb the selection inputs mid-frame
      gap_req = 8'd3; gap_adj_en = ~gap_adj_en;
      full_duplex = ~full_duplex; phy_rgmii = ~phy_rgmii;
      repeat (4) @(negedge clk);
      run_gap(n);
      check(n == int'(VEC[i][7:0]), $sformatf("R8 R2-7 vector %0d", i), n, int'(VEC[i][7:0]));
    end

    // R10: ready falls right after frame_end, stays low during a stall (R9)
    full_duplex = 1'b0; phy_rgmii = 1'b0; gap_adj_en = 1'b0;
    @(negedge clk) sof_req = 1'b1;
    @(negedge clk) sof_req = 1'b0;
    byte_en = 1'b0;
    @(negedge clk) frame_end = 1'b1;
    @(negedge clk) frame_end = 1'b0;
    check(tx_ready == 1'b0, "R10 ready falls after frame_end", tx_ready, 0);
    repeat (40) @(negedge clk);
    check(tx_ready == 1'b0, "R9 no count without byte_en", tx_ready, 0);
    byte_en = 1'b1;
    n = 0;
    while (!tx_ready && n < 300) begin n++; @(negedge clk); end
    check(n == 18, "R9 full count after stall", n, 18);

    // R9: byte_en every other cycle doubles the wait
    full_duplex = 1'b1;
    @(negedge clk) sof_req = 1'b1;
    @(negedge clk) sof_req = 1'b0;
    @(negedge clk) frame_end = 1'b1;
    @(negedge clk) frame_end = 1'b0;
    n = 0;
    while (!tx_ready && n < 300) begin
      n++;
      byte_en = ~byte_en;
      @(negedge clk);
    end
    byte_en = 1'b1;
    check(n == 24 || n == 23, "R9 half-rate enable", n, 24);

    // R1: reset in mid-gap clears the pending gap
    @(negedge clk) frame_end = 1'b1;
    @(negedge clk) frame_end = 1'b0;
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(tx_ready == 1'b1, "R1 reset clears gap", tx_ready, 1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule